// File: doc/BRIEF.md
# Circular RAM Address Post-Modify Unit

This block generates data-memory addresses for a processor datapath. It holds a bank of pointer registers and three shared registers: a base, an end and a signed stride. Each access names one pointer and one update mode in a 4-bit field. The pointer's current value leaves the block as the address in the same cycle. On the clock edge that ends the access, the pointer takes its new value.

The update modes are: keep the pointer, step it up by one, step it down by one, or add the stride. When stepping up, the pointer can run over a circular buffer. If the end register is nonzero and matches the pointer, the pointer reloads from the base register instead of incrementing. An end value of zero turns the circular behaviour off.

All registers are loaded through one write port. A parameter sets the register width to either 9 or 16 bits. Pointer, base and end loads keep only the low width bits. Stride loads are sign-extended from the top bit of that width. Every pointer result is truncated to the width, so the arithmetic wraps modulo two to the width.

Top module: `circ_addr_unit`

## Requirements
- R1: After reset every pointer, the base, the end and the stride are zero, so an access to any pointer presents address 0.
- R2: Bits 3:2 of `acc_field` pick the pointer (0 to 3), and `addr_o` shows that pointer's value before any update from the current access.
- R3: Mode code 0 (bits 1:0 of `acc_field`) leaves the chosen pointer unchanged.
- R4: Mode code 1 increments the chosen pointer by one, truncated to the register width (at width 9, 0x1FF becomes 0x000).
- R5: In mode code 1, when the end register is nonzero and equals the pointer, the pointer takes the base value instead of incrementing.
- R6: With the end register at zero, mode code 1 always increments and never reloads from the base.
- R7: Mode code 2 decrements the chosen pointer by one, truncated to the width (0 becomes all ones).
- R8: Mode code 3 adds the stride to the chosen pointer, truncated to the width. The stride is loaded sign-extended from bit width-1 of `ld_data`, and the bits above the width are ignored (at width 9, 0x03FE acts as -2 and 0xFE00 acts as 0).
- R9: Pointer, base and end loads keep only the low width bits of `ld_data`.
- R10: A pointer changes only on a clock edge where `acc_en` selects it or a load targets it. `acc_field` has no effect while `acc_en` is low.
- R11: Loads use `ld_sel` codes 0 to 3 for pointers, 4 for base, 5 for end and 6 for stride. A pointer load in the same cycle as an access to that pointer wins over the access update. An access to a different pointer in that cycle still updates.
- R12: `ld_sel` code 7 changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_en | input | 1 | Access strobe; commits the pointer update at the next edge |
| acc_field | input | 4 | Pointer select in bits 3:2, update mode in bits 1:0 |
| addr_o | output | PTR_W (16) | Selected pointer value before update |
| ld_en | input | 1 | Register load strobe |
| ld_sel | input | 3 | Load target: 0-3 pointer, 4 base, 5 end, 6 stride, 7 none |
| ld_data | input | DATA_W (16) | Load value, conditioned to the register width |

## Verification
The bench builds the unit at a register width of 9 with 16-bit load data. At that width the mask boundary sits at 0x1FF, so a few accesses reach it. This makes visible the cases a 16-bit build would hide:
- increment and decrement wrapping at the width,
- stride sign extension from bit 8, with the upper load bits discarded,
- base and end truncation.

The circular reload is driven through a short buffer, both with the end register set and with it at zero. Load and access collisions are exercised on the same pointer and on different pointers.

// File: rtl/cam_pkg.sv
package cam_pkg;

   // update applied to the selected pointer, encoded in field bits 1:0
   typedef enum logic [1:0] {
      STEP_KEEP = 2'd0,
      STEP_INC  = 2'd1,
      STEP_DEC  = 2'd2,
      STEP_ADD  = 2'd3
   } step_e;

endpackage

// File: rtl/cam_value_cond.sv
// Fits a load word to the register width: truncate, then either zero-fill
// or sign-extend to OUT_W.
module cam_value_cond #(
   parameter int DATA_W   = 16,
   parameter int VAL_W    = 9,
   parameter int OUT_W    = 9,
   parameter bit SIGN_EXT = 1'b0
) (
   input  logic [DATA_W-1:0] din,
   output logic [OUT_W-1:0]  dout
);

   if (VAL_W > DATA_W || OUT_W < VAL_W) begin : g_bad_cfg
      initial $fatal(1, "cam_value_cond: VAL_W must fit in DATA_W and OUT_W");
   end

   logic [VAL_W-1:0] low_bits;
   assign low_bits = din[VAL_W-1:0];

   if (DATA_W > VAL_W) begin : g_drop_hi
      logic unused_hi;
      assign unused_hi = ^din[DATA_W-1:VAL_W];
   end

   if (OUT_W == VAL_W) begin : g_same
      assign dout = low_bits;
   end else if (SIGN_EXT) begin : g_sext
      assign dout = {{(OUT_W-VAL_W){low_bits[VAL_W-1]}}, low_bits};
   end else begin : g_zext
      assign dout = {{(OUT_W-VAL_W){1'b0}}, low_bits};
   end

endmodule

// File: rtl/cam_step.sv
// Next-value computation for one pointer.
module cam_step
   import cam_pkg::*;
#(
   parameter int PTR_W  = 16,
   parameter int DATA_W = 16
) (
   input  logic [PTR_W-1:0]  cur,
   input  step_e             step,
   input  logic [PTR_W-1:0]  base_q,
   input  logic [PTR_W-1:0]  end_q,
   input  logic [DATA_W-1:0] stride_q,
   output logic [PTR_W-1:0]  nxt
);

   logic [DATA_W-1:0] sum;
   logic              at_end;

   assign sum    = DATA_W'(cur) + stride_q;
   assign at_end = (end_q != '0) && (cur == end_q);

   if (DATA_W > PTR_W) begin : g_sum_hi
      logic unused_sum_hi;
      assign unused_sum_hi = ^sum[DATA_W-1:PTR_W];
   end

   always_comb begin
      unique case (step)
         STEP_KEEP: nxt = cur;
         STEP_INC:  nxt = at_end ? base_q : cur + 1'b1;
         STEP_DEC:  nxt = cur - 1'b1;
         STEP_ADD:  nxt = sum[PTR_W-1:0];
         default:   nxt = cur;
      endcase
   end

endmodule

// File: rtl/cam_ptr_bank.sv
// Pointer registers. A load has priority over an access update.
module cam_ptr_bank #(
   parameter int PTR_W    = 16,
   parameter int NUM_PTR  = 4,
   parameter int SEL_W    = 2,
   parameter int LD_SEL_W = 3
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            ld_en,
   input  logic [LD_SEL_W-1:0]             ld_sel,
   input  logic [PTR_W-1:0]                ld_val,
   input  logic                            acc_en,
   input  logic [SEL_W-1:0]                acc_sel,
   input  logic [PTR_W-1:0]                nxt,
   output logic [NUM_PTR-1:0][PTR_W-1:0]   ptr_q
);

   for (genvar i = 0; i < NUM_PTR; i++) begin : g_ptr
      logic [PTR_W-1:0] r_q;
      logic             ld_hit;
      logic             acc_hit;

      assign ld_hit  = ld_en && (ld_sel == LD_SEL_W'(i));
      assign acc_hit = acc_en && (acc_sel == SEL_W'(i));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)       r_q <= '0;
         else if (ld_hit)  r_q <= ld_val;
         else if (acc_hit) r_q <= nxt;
      end

      assign ptr_q[i] = r_q;
   end

   // R10: with neither strobe, no pointer moves
   assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!ld_en && !acc_en) |=> $stable(ptr_q));

   // R11: a pointer load always lands, whatever the access does
   assert_load_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_en && (int'(ld_sel) < NUM_PTR)) |=>
      (ptr_q[$past(ld_sel[SEL_W-1:0])] == $past(ld_val)));

endmodule

// File: rtl/circ_addr_unit.sv
module circ_addr_unit
   import cam_pkg::*;
#(
   parameter int  PTR_W    = 16,
   parameter int  DATA_W   = 16,
   parameter int  NUM_PTR  = 4,
   localparam int SEL_W    = $clog2(NUM_PTR),
   localparam int FIELD_W  = SEL_W + 2,
   localparam int LD_SEL_W = $clog2(NUM_PTR + 4)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                acc_en,
   input  logic [FIELD_W-1:0]  acc_field,
   output logic [PTR_W-1:0]    addr_o,
   input  logic                ld_en,
   input  logic [LD_SEL_W-1:0] ld_sel,
   input  logic [DATA_W-1:0]   ld_data
);

   localparam int BASE_CODE   = NUM_PTR;
   localparam int END_CODE    = NUM_PTR + 1;
   localparam int STRIDE_CODE = NUM_PTR + 2;

   if (!(PTR_W == 9 || PTR_W == 16)) begin : g_bad_width
      initial $fatal(1, "circ_addr_unit: PTR_W must be 9 or 16");
   end
   if (DATA_W < PTR_W) begin : g_bad_data
      initial $fatal(1, "circ_addr_unit: DATA_W must be at least PTR_W");
   end
   if (NUM_PTR != 4) begin : g_bad_count
      initial $fatal(1, "circ_addr_unit: the 4-bit field needs NUM_PTR = 4");
   end

   logic [SEL_W-1:0]                sel;
   step_e                           step;
   logic [PTR_W-1:0]                ld_masked;
   logic [DATA_W-1:0]               ld_sext;
   logic [PTR_W-1:0]                base_q;
   logic [PTR_W-1:0]                end_q;
   logic [DATA_W-1:0]               stride_q;
   logic [PTR_W-1:0]                nxt;
   logic [NUM_PTR-1:0][PTR_W-1:0]   ptr_q;

   assign sel    = acc_field[FIELD_W-1:2];
   assign step   = step_e'(acc_field[1:0]);
   assign addr_o = ptr_q[sel];

   cam_value_cond #(
      .DATA_W(DATA_W), .VAL_W(PTR_W), .OUT_W(PTR_W), .SIGN_EXT(1'b0)
   ) u_mask (
      .din(ld_data), .dout(ld_masked)
   );

   cam_value_cond #(
      .DATA_W(DATA_W), .VAL_W(PTR_W), .OUT_W(DATA_W), .SIGN_EXT(1'b1)
   ) u_sext (
      .din(ld_data), .dout(ld_sext)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q   <= '0;
         end_q    <= '0;
         stride_q <= '0;
      end else if (ld_en) begin
         if (ld_sel == LD_SEL_W'(BASE_CODE))   base_q   <= ld_masked;
         if (ld_sel == LD_SEL_W'(END_CODE))    end_q    <= ld_masked;
         if (ld_sel == LD_SEL_W'(STRIDE_CODE)) stride_q <= ld_sext;
      end
   end

   cam_step #(.PTR_W(PTR_W), .DATA_W(DATA_W)) u_step (
      .cur(addr_o), .step(step), .base_q(base_q), .end_q(end_q),
      .stride_q(stride_q), .nxt(nxt)
   );

   cam_ptr_bank #(
      .PTR_W(PTR_W), .NUM_PTR(NUM_PTR), .SEL_W(SEL_W), .LD_SEL_W(LD_SEL_W)
   ) u_bank (
      .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_sel(ld_sel),
      .ld_val(ld_masked), .acc_en(acc_en), .acc_sel(sel), .nxt(nxt),
      .ptr_q(ptr_q)
   );

   // access whose pointer is not overwritten by a load in the same cycle
   logic acc_clean;
   assign acc_clean = acc_en && !(ld_en && (ld_sel == LD_SEL_W'(sel)));

   assert_keep_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_clean && step == STEP_KEEP) |=> (ptr_q[$past(sel)] == $past(addr_o)));

   assert_wrap_to_base_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_clean && step == STEP_INC && end_q != '0 && addr_o == end_q) |=>
      (ptr_q[$past(sel)] == $past(base_q)));

   assert_plain_inc_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_clean && step == STEP_INC && end_q == '0) |=>
      (ptr_q[$past(sel)] == PTR_W'($past(addr_o) + 1'b1)));

   assert_dec_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_clean && step == STEP_DEC) |=>
      (ptr_q[$past(sel)] == PTR_W'($past(addr_o) - 1'b1)));

   assert_stride_add_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_clean && step == STEP_ADD) |=>
      (ptr_q[$past(sel)] == PTR_W'(DATA_W'($past(addr_o)) + $past(stride_q))));

endmodule

// File: tb/circ_addr_unit_bench.sv
`timescale 1ns/1ps
module circ_addr_unit_bench;

   localparam int W    = 9;
   localparam int DW   = 16;
   localparam int MASK = (1 << W) - 1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          acc_en = 1'b0;
   logic [3:0]    acc_field = '0;
   logic [W-1:0]  addr_o;
   logic          ld_en = 1'b0;
   logic [2:0]    ld_sel = '0;
   logic [DW-1:0] ld_data = '0;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   circ_addr_unit #(.PTR_W(W), .DATA_W(DW), .NUM_PTR(4)) u_circ_addr_unit (
      .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_field(acc_field),
      .addr_o(addr_o), .ld_en(ld_en), .ld_sel(ld_sel), .ld_data(ld_data)
   );

   // reference state kept from the requirements
   int m_ptr[4];
   int m_base = 0;
   int m_end = 0;
   int m_stride = 0;

   int    exp_q[$];
   string tag_q[$];

   function automatic int model_next(int cur, int mode);
      case (mode)
         0: return cur;
         1: return (m_end != 0 && m_end == cur) ? m_base : ((cur + 1) & MASK);
         2: return (cur - 1) & MASK;
         default: return (cur + m_stride) & MASK;
      endcase
   endfunction

   function automatic void model_load(int sel, int data);
      int v;
      v = data & MASK;
      if (sel < 4) m_ptr[sel] = v;
      else if (sel == 4) m_base = v;
      else if (sel == 5) m_end = v;
      else if (sel == 6) m_stride = (v >= (1 << (W-1))) ? v - (1 << W) : v;
   endfunction

   task automatic access(int p, int mode, string tag);
      @(posedge clk); #1;
      acc_en = 1'b1; acc_field = 4'((p << 2) | mode); ld_en = 1'b0;
      exp_q.push_back(m_ptr[p]); tag_q.push_back(tag);
      m_ptr[p] = model_next(m_ptr[p], mode);
   endtask

   task automatic load(int sel, int data);
      @(posedge clk); #1;
      acc_en = 1'b0; ld_en = 1'b1; ld_sel = 3'(sel); ld_data = 16'(data);
      model_load(sel, data);
   endtask

   task automatic load_access(int sel, int data, int p, int mode, string tag);
      @(posedge clk); #1;
      acc_en = 1'b1; acc_field = 4'((p << 2) | mode);
      ld_en = 1'b1; ld_sel = 3'(sel); ld_data = 16'(data);
      exp_q.push_back(m_ptr[p]); tag_q.push_back(tag);
      m_ptr[p] = model_next(m_ptr[p], mode);
      model_load(sel, data);
   endtask

   task automatic no_strobe(int field);
      @(posedge clk); #1;
      acc_en = 1'b0; ld_en = 1'b0; acc_field = 4'(field);
   endtask

   task automatic idle();
      @(posedge clk); #1;
      acc_en = 1'b0; ld_en = 1'b0;
   endtask

   // monitor: compares each presented address against the queued prediction
   always @(negedge clk) begin : monitor
      int    e;
      string t;
      if (rst_n && acc_en) begin
         checks++;
         if (exp_q.size() == 0) begin
            failures++;
            $display("FAIL scoreboard empty got=%h expected=none", addr_o);
         end else begin
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            if (int'(addr_o) != e) begin
               failures++;
               $display("FAIL %s addr=%h expected=%h", t, addr_o, e[W-1:0]);
            end
         end
      end
   end

   initial begin : watchdog
      repeat (50000) @(posedge clk);
      if (!done) begin
         checks++; failures++;
         $display("FAIL watchdog expired got=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin : stimulus
      for (int i = 0; i < 4; i++) m_ptr[i] = 0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1: all pointers read zero after reset
      for (int i = 0; i < 4; i++) access(i, 0, "R1");
      // R8: stride zero after reset, add leaves pointer
      access(2, 3, "R1");
      access(2, 0, "R1");

      // R9: masked loads
      load(0, 16'h0010);
      load(1, 16'hFFFF);
      load(4, 16'h1234);
      load(5, 16'hFE13);
      load(2, 16'h0A05);
      load(3, 16'h0005);
      // R2: each pointer presents its own value
      access(1, 0, "R9");
      access(2, 0, "R2");
      access(3, 0, "R2");
      access(0, 0, "R2");
      // R3: keep mode repeated
      access(0, 0, "R3");
      access(0, 0, "R3");

      // R4/R5: run up to the end value and reload from base
      access(0, 1, "R4");
      access(0, 1, "R4");
      access(0, 1, "R4");
      access(0, 1, "R5");
      access(0, 1, "R5");
      access(0, 0, "R5");

      // R6: end cleared, pointer at 0x1FF steps through the mask boundary
      load(5, 16'h0000);
      access(1, 1, "R6");
      access(1, 1, "R4");
      access(1, 0, "R6");
      load(0, 16'h0034);
      access(0, 1, "R6");
      access(0, 0, "R6");

      // R7: decrement across zero
      load(2, 16'h0000);
      access(2, 2, "R7");
      access(2, 2, "R7");
      access(2, 0, "R7");

      // R8: negative stride from bit 8, then positive, then high bits only
      load(6, 16'h03FE);
      access(3, 3, "R8");
      access(3, 3, "R8");
      access(3, 3, "R8");
      access(3, 3, "R8");
      access(3, 0, "R8");
      load(6, 16'h0007);
      access(3, 3, "R8");
      access(3, 0, "R8");
      load(6, 16'hFE00);
      access(3, 3, "R8");
      access(3, 0, "R8");

      // R10: field wiggles without the strobe
      no_strobe(4'b0001);
      no_strobe(4'b0110);
      no_strobe(4'b1011);
      no_strobe(4'b1111);
      for (int i = 0; i < 4; i++) access(i, 0, "R10");

      // R11: load and access collide on one pointer, then on different ones
      load_access(0, 16'h0100, 0, 1, "R11");
      access(0, 0, "R11");
      load_access(1, 16'h0077, 2, 2, "R11");
      access(1, 0, "R11");
      access(2, 0, "R11");

      // R12: code 7 leaves every register alone
      load(6, 16'h0002);
      load(5, 16'h0102);
      load(4, 16'h0040);
      load(7, 16'h01FF);
      for (int i = 0; i < 4; i++) access(i, 0, "R12");
      access(0, 1, "R12");
      access(0, 1, "R12");
      access(0, 1, "R12");
      access(0, 0, "R12");
      access(3, 3, "R12");
      access(3, 0, "R12");

      idle();
      idle();
      done = 1'b1;
      if (exp_q.size() != 0) begin
         checks++; failures++;
         $display("FAIL scoreboard leftover got=%0d expected=0", exp_q.size());
      end
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule